// File: doc/BRIEF.md
# Per-Cell Waveform Offset Calibrator

A switched-capacitor sampling array stores each waveform point on one of a ring of capacitor cells, and every cell carries its own fixed pedestal. This block learns those pedestals and removes them from the sample stream. Every incoming sample arrives with the physical index of the cell that held it. Readout starts wherever sampling stopped, so the cell index is not the position of the sample within the readout.

In calibration mode a start strobe begins a learning pass. Upstream logic drives the array inputs with a zero-volt reference and streams sixteen full readouts of the ring. For each cell the block adds up its sixteen readings in an accumulator memory. It then stores the sum, shifted right arithmetically by four, in a 12-bit correction table addressed by the cell number, and raises a done flag. In run mode each sample passes through a two-stage pipeline. That pipeline subtracts the table entry of its cell and clips the result to the signed sample range, then hands it straight to the timing discriminator that follows.

Top module: `offset_calibrator`

## Requirements
- R1: While reset is high, and on the first edge after it, out_valid and cal_done are low.
- R2: A start pulse with cal_mode=1 begins a calibration. The next 16×1024 accepted samples (in_valid=1, cal_mode=1) are summed per in_cell. Each table entry becomes floor(sum/16), which is the 16-bit sum shifted right arithmetically by 4.
- R3: cal_done rises on the second rising edge after the final accepted calibration sample is presented. It stays high until a start pulse with cal_mode=1, and it is low one edge after that pulse.
- R4: Calibration-mode samples presented after calibration has finished, and with no new start, leave the table unchanged and produce no output.
- R5: A start pulse during a calibration discards the partial sums and restarts the capture count from zero.
- R6: In run mode (cal_mode=0) a valid sample gives out_valid=1 and out_sample = in_sample − table[in_cell], both two rising edges later. Samples are 12-bit two's complement, and the entry is selected by in_cell regardless of readout order.
- R7: The corrected value is clipped to +2047 and −2048.
- R8: out_valid is low two edges after any cycle that has in_valid=0 or cal_mode=1.
- R9: When two accepted samples in a row carry the same cell index, both contribute to that cell's sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cal_mode | input | 1 | 1 = calibration, 0 = run |
| start | input | 1 | Begins (or restarts) a calibration when cal_mode=1 |
| in_valid | input | 1 | Sample present this cycle |
| in_sample | input | 12 | Signed sample |
| in_cell | input | 10 | Physical cell index of the sample |
| out_valid | output | 1 | Corrected sample present |
| out_sample | output | 12 | Signed, offset-corrected, clipped sample |
| cal_done | output | 1 | All table entries written by the last calibration |

## Verification
Writing one sample's running sum back to the accumulator memory and reading the stored sum for the next sample can fall in the same cycle and hit the same cell. That happens at each pass boundary when the next readout starts on the cell where the previous one ended. The bench provokes it by moving the stop cell back by one cell on every pass. It then reads back the whole table in run mode with zero input and compares each cell against independently computed floor averages, with the boundary cells judged under R9. If forwarding were missing, those cells would lose one reading.

// File: rtl/oc_pkg.sv
package oc_pkg;

  typedef enum logic [1:0] {
    CAL_IDLE   = 2'd0,
    CAL_ACTIVE = 2'd1,
    CAL_DRAIN  = 2'd2,
    CAL_DONE   = 2'd3
  } cal_state_e;

endpackage

// File: rtl/oc_sdp_ram.sv
module oc_sdp_ram #(
  parameter int WIDTH = 12,
  parameter int DEPTH = 1024,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] mem [DEPTH];

  // plain dual-port body so block RAM is inferred; read returns old data
  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/oc_cal_engine.sv
module oc_cal_engine
  import oc_pkg::*;
#(
  parameter int SMP_W    = 12,
  parameter int CELLS    = 1024,
  parameter int CELL_W   = $clog2(CELLS),
  parameter int AVG_LOG2 = 4,
  parameter int SUM_W    = SMP_W + AVG_LOG2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cal_mode,
  input  logic                    start,
  input  logic                    in_valid,
  input  logic signed [SMP_W-1:0] in_sample,
  input  logic [CELL_W-1:0]       in_cell,
  // accumulator memory
  input  logic [SUM_W-1:0]        acc_rdata,
  output logic                    acc_we,
  output logic [CELL_W-1:0]       acc_waddr,
  output logic [SUM_W-1:0]        acc_wdata,
  // correction table write side
  output logic                    tab_we,
  output logic [CELL_W-1:0]       tab_waddr,
  output logic [SMP_W-1:0]        tab_wdata,
  output logic                    done
);

  localparam int CAPS = 1 << AVG_LOG2;

  cal_state_e state;
  logic [CELL_W-1:0]       pass_pos;
  logic [AVG_LOG2-1:0]     cap_idx;
  logic                    restart;
  logic                    accept;
  logic                    last_smp;

  // stage 1: waiting for the accumulator read
  logic                    s1_v;
  logic [CELL_W-1:0]       s1_cell;
  logic signed [SMP_W-1:0] s1_smp;
  logic                    s1_first;
  logic                    s1_final;

  // copy of the write that just committed, for read-after-write on one cell
  logic                    wq_v;
  logic [CELL_W-1:0]       wq_addr;
  logic [SUM_W-1:0]        wq_data;

  logic signed [SUM_W-1:0] prior;
  logic signed [SUM_W-1:0] sum;

  assign restart  = start && cal_mode;
  assign accept   = (state == CAL_ACTIVE) && in_valid && cal_mode && !restart;
  assign last_smp = (cap_idx == AVG_LOG2'(CAPS - 1)) &&
                    (pass_pos == CELL_W'(CELLS - 1));

  always_comb begin
    if (wq_v && (wq_addr == s1_cell)) begin
      prior = $signed(wq_data);
    end else begin
      prior = $signed(acc_rdata);
    end
    if (s1_first) begin
      sum = SUM_W'(s1_smp);
    end else begin
      sum = prior + SUM_W'(s1_smp);
    end
  end

  assign acc_we    = s1_v;
  assign acc_waddr = s1_cell;
  assign acc_wdata = sum;
  assign tab_we    = s1_v && s1_final;
  assign tab_waddr = s1_cell;
  assign tab_wdata = SMP_W'(sum >>> AVG_LOG2);
  assign done      = (state == CAL_DONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= CAL_IDLE;
      pass_pos <= '0;
      cap_idx  <= '0;
      s1_v     <= 1'b0;
      s1_cell  <= '0;
      s1_smp   <= '0;
      s1_first <= 1'b0;
      s1_final <= 1'b0;
      wq_v     <= 1'b0;
      wq_addr  <= '0;
      wq_data  <= '0;
    end else begin
      s1_v     <= accept;
      s1_cell  <= in_cell;
      s1_smp   <= in_sample;
      s1_first <= (cap_idx == '0);
      s1_final <= (cap_idx == AVG_LOG2'(CAPS - 1));
      wq_v     <= s1_v;
      wq_addr  <= s1_cell;
      wq_data  <= sum;

      if (restart) begin
        state    <= CAL_ACTIVE;
        pass_pos <= '0;
        cap_idx  <= '0;
        s1_v     <= 1'b0;
        wq_v     <= 1'b0;
      end else begin
        unique case (state)
          CAL_ACTIVE: begin
            if (accept) begin
              if (last_smp) begin
                state <= CAL_DRAIN;
              end
              if (pass_pos == CELL_W'(CELLS - 1)) begin
                pass_pos <= '0;
                cap_idx  <= cap_idx + 1'b1;
              end else begin
                pass_pos <= pass_pos + 1'b1;
              end
            end
          end
          CAL_DRAIN: state <= CAL_DONE;
          default:   state <= state;
        endcase
      end
    end
  end

endmodule

// File: rtl/oc_correct.sv
module oc_correct #(
  parameter int SMP_W = 12
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic signed [SMP_W-1:0] in_sample,
  input  logic [SMP_W-1:0]        offset,
  output logic                    out_valid,
  output logic signed [SMP_W-1:0] out_sample
);

  localparam int DW = SMP_W + 1;
  localparam logic signed [DW-1:0] HI = DW'((1 << (SMP_W - 1)) - 1);
  localparam logic signed [DW-1:0] LO = -DW'(1 << (SMP_W - 1));

  logic                    s1_v;
  logic signed [SMP_W-1:0] s1_smp;
  logic signed [DW-1:0]    diff;
  logic signed [SMP_W-1:0] clipped;

  always_comb begin
    diff = DW'(s1_smp) - DW'($signed(offset));
    if (diff > HI) begin
      clipped = SMP_W'(HI);
    end else if (diff < LO) begin
      clipped = SMP_W'(LO);
    end else begin
      clipped = SMP_W'(diff);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v       <= 1'b0;
      s1_smp     <= '0;
      out_valid  <= 1'b0;
      out_sample <= '0;
    end else begin
      s1_v       <= in_valid;
      s1_smp     <= in_sample;
      out_valid  <= s1_v;
      out_sample <= clipped;
    end
  end

endmodule

// File: rtl/offset_calibrator.sv
module offset_calibrator #(
  parameter int SMP_W    = 12,
  parameter int CELLS    = 1024,
  parameter int CELL_W   = $clog2(CELLS),
  parameter int AVG_LOG2 = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cal_mode,
  input  logic                    start,
  input  logic                    in_valid,
  input  logic signed [SMP_W-1:0] in_sample,
  input  logic [CELL_W-1:0]       in_cell,
  output logic                    out_valid,
  output logic signed [SMP_W-1:0] out_sample,
  output logic                    cal_done
);

  localparam int SUM_W = SMP_W + AVG_LOG2;

  logic [SUM_W-1:0]  acc_rdata;
  logic              acc_we;
  logic [CELL_W-1:0] acc_waddr;
  logic [SUM_W-1:0]  acc_wdata;
  logic              tab_we;
  logic [CELL_W-1:0] tab_waddr;
  logic [SMP_W-1:0]  tab_wdata;
  logic [SMP_W-1:0]  tab_rdata;
  logic              run_valid;

  assign run_valid = in_valid && !cal_mode;

  oc_cal_engine #(
    .SMP_W(SMP_W), .CELLS(CELLS), .CELL_W(CELL_W), .AVG_LOG2(AVG_LOG2), .SUM_W(SUM_W)
  ) u_cal (
    .clk(clk), .rst(rst), .cal_mode(cal_mode), .start(start),
    .in_valid(in_valid), .in_sample(in_sample), .in_cell(in_cell),
    .acc_rdata(acc_rdata), .acc_we(acc_we), .acc_waddr(acc_waddr), .acc_wdata(acc_wdata),
    .tab_we(tab_we), .tab_waddr(tab_waddr), .tab_wdata(tab_wdata), .done(cal_done)
  );

  oc_sdp_ram #(.WIDTH(SUM_W), .DEPTH(CELLS), .AW(CELL_W)) u_acc (
    .clk(clk), .we(acc_we), .waddr(acc_waddr), .wdata(acc_wdata),
    .raddr(in_cell), .rdata(acc_rdata)
  );

  oc_sdp_ram #(.WIDTH(SMP_W), .DEPTH(CELLS), .AW(CELL_W)) u_table (
    .clk(clk), .we(tab_we), .waddr(tab_waddr), .wdata(tab_wdata),
    .raddr(in_cell), .rdata(tab_rdata)
  );

  oc_correct #(.SMP_W(SMP_W)) u_corr (
    .clk(clk), .rst(rst), .in_valid(run_valid), .in_sample(in_sample),
    .offset(tab_rdata), .out_valid(out_valid), .out_sample(out_sample)
  );

endmodule

// File: rtl/oc_checker.sv
module oc_checker #(
  parameter int CELLS  = 1024,
  parameter int CELL_W = $clog2(CELLS)
) (
  input logic clk,
  input logic rst,
  input logic cal_mode,
  input logic start,
  input logic in_valid,
  input logic out_valid,
  input logic cal_done,
  input logic tab_we
);

  logic [CELL_W:0] wr_count;

  always_ff @(posedge clk) begin
    if (rst || (start && cal_mode)) begin
      wr_count <= '0;
    end else if (tab_we) begin
      wr_count <= wr_count + 1'b1;
    end
  end

  AST_RST_QUIET: assert property (@(posedge clk)
    rst |=> (!out_valid && !cal_done)); // R1

  AST_FILL_COMPLETE: assert property (@(posedge clk) disable iff (rst)
    $rose(cal_done) |-> (wr_count == (CELL_W + 1)'(CELLS))); // R2

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (cal_done && !(start && cal_mode)) |=> cal_done); // R3

  AST_DONE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (start && cal_mode) |=> !cal_done); // R3

  AST_NO_WRITE_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    tab_we |-> !cal_done); // R4

  AST_VALID_SOURCE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !$past(rst, 2)) |-> $past(in_valid && !cal_mode, 2)); // R8

endmodule

bind offset_calibrator oc_checker #(.CELLS(CELLS), .CELL_W(CELL_W)) u_oc_checker (
  .clk(clk), .rst(rst), .cal_mode(cal_mode), .start(start), .in_valid(in_valid),
  .out_valid(out_valid), .cal_done(cal_done), .tab_we(tab_we)
);

// File: tb/tb_offset_calibrator.sv
module tb_offset_calibrator;

  localparam int NC = 1024;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cal_mode = 1'b1;
  logic              start = 1'b0;
  logic              in_valid = 1'b0;
  logic signed [11:0] in_sample = '0;
  logic [9:0]        in_cell = '0;
  logic              out_valid;
  logic signed [11:0] out_sample;
  logic              cal_done;

  offset_calibrator dut (
    .clk(clk), .rst(rst), .cal_mode(cal_mode), .start(start), .in_valid(in_valid),
    .in_sample(in_sample), .in_cell(in_cell), .out_valid(out_valid),
    .out_sample(out_sample), .cal_done(cal_done)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int exp_tab [NC];
  int sum_m   [NC];
  bit edge_cell [NC];

  logic              ex_v [2];
  logic signed [11:0] ex_s [2];
  string             ex_r [2];

  function automatic int clip12(input int x);
    if (x > 2047) return 2047;
    if (x < -2048) return -2048;
    return x;
  endfunction

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  // one clock: check the output due from two steps ago, then drive new inputs
  task automatic step(input logic md, input logic st, input logic v, input int s,
                      input int c, input string r);
    @(negedge clk);
    if (ex_v[1]) begin
      chk(out_valid === 1'b1, {ex_r[1], " out_valid"}, int'(out_valid), 1);
      chk(out_sample === ex_s[1], ex_r[1], int'(out_sample), int'(ex_s[1]));
    end else begin
      chk(out_valid === 1'b0, "R8 out_valid", int'(out_valid), 0);
    end
    ex_v[1] = ex_v[0];
    ex_s[1] = ex_s[0];
    ex_r[1] = ex_r[0];
    ex_v[0] = v && !md;
    ex_s[0] = 12'(clip12(s - exp_tab[c]));
    ex_r[0] = r;
    cal_mode  = md;
    start     = st;
    in_valid  = v;
    in_sample = s[11:0];
    in_cell   = c[9:0];
  endtask

  task automatic idle(input logic md, input int n);
    for (int i = 0; i < n; i++) step(md, 1'b0, 1'b0, 0, 0, "R8");
  endtask

  function automatic int pedestal(input int c, input int shift);
    return ((c * 37) % 301) - 150 + shift;
  endfunction

  // sixteen rotated readouts of a zero-volt reference
  task automatic calibrate(input int seed, input int shift, input int stop0);
    step(1'b1, 1'b1, 1'b0, 0, 0, "R3");
    step(1'b1, 1'b0, 1'b0, 0, 0, "R3");
    chk(cal_done === 1'b0, "R3 done cleared by start", int'(cal_done), 0);
    for (int c = 0; c < NC; c++) begin
      sum_m[c] = 0;
      edge_cell[c] = 1'b0;
    end
    for (int k = 0; k < 16; k++) begin
      int stop;
      stop = (((stop0 - k) % NC) + NC) % NC;
      if (k > 0) edge_cell[stop] = 1'b1;
      for (int i = 0; i < NC; i++) begin
        int c;
        int v;
        c = (stop + i) % NC;
        v = pedestal(c, shift) + ((c * 3 + k * 11 + seed) % 9) - 4;
        sum_m[c] += v;
        if (k == 2 && (i % 7) == 0) step(1'b1, 1'b0, 1'b0, 0, 0, "R8");
        step(1'b1, 1'b0, 1'b1, v, c, "R8");
        if (k == 15 && i == NC - 1)
          chk(cal_done === 1'b0, "R3 done low at final sample", int'(cal_done), 0);
      end
    end
    step(1'b1, 1'b0, 1'b0, 0, 0, "R8");
    chk(cal_done === 1'b0, "R3 done low one edge after final", int'(cal_done), 0);
    step(1'b1, 1'b0, 1'b0, 0, 0, "R8");
    chk(cal_done === 1'b1, "R3 done high two edges after final", int'(cal_done), 1);
    for (int c = 0; c < NC; c++) exp_tab[c] = sum_m[c] >>> 4;
  endtask

  // zero input in run mode returns the negated table entry of every cell
  task automatic readback(input string r);
    for (int c = 0; c < NC; c++)
      step(1'b0, 1'b0, 1'b1, 0, c, edge_cell[c] ? "R9 boundary cell" : r);
    idle(1'b0, 2);
  endtask

  task automatic t_reset;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(out_valid === 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
    chk(cal_done === 1'b0, "R1 cal_done in reset", int'(cal_done), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid === 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    chk(cal_done === 1'b0, "R1 cal_done after reset", int'(cal_done), 0);
  endtask

  task automatic t_no_start;
    for (int i = 0; i < 40; i++) step(1'b1, 1'b0, 1'b1, 500, i, "R8");
    idle(1'b1, 2);
    chk(cal_done === 1'b0, "R4 no calibration without start", int'(cal_done), 0);
  endtask

  task automatic t_run_rotated;
    for (int i = 0; i < NC; i++) begin
      int c;
      c = (777 + i) % NC;
      if ((i % 13) == 5) step(1'b0, 1'b0, 1'b0, 0, 0, "R8");
      step(1'b0, 1'b0, 1'b1, ((i * 113) % 1500) - 750, c, "R6 rotated stream");
    end
    idle(1'b0, 2);
  endtask

  task automatic t_saturate;
    int neg_c;
    int pos_c;
    neg_c = -1;
    pos_c = -1;
    for (int c = 0; c < NC; c++) begin
      if (exp_tab[c] < 0 && neg_c < 0) neg_c = c;
      if (exp_tab[c] > 0 && pos_c < 0) pos_c = c;
    end
    chk(neg_c >= 0 && pos_c >= 0, "R7 setup", neg_c, 0);
    step(1'b0, 1'b0, 1'b1, 2047, neg_c, "R7 high clip");
    step(1'b0, 1'b0, 1'b1, -2048, pos_c, "R7 low clip");
    step(1'b0, 1'b0, 1'b1, 2047, pos_c, "R7 near top unclipped");
    step(1'b0, 1'b0, 1'b1, -2048, neg_c, "R7 near bottom unclipped");
    idle(1'b0, 2);
  endtask

  task automatic t_ignore_after_done;
    for (int k = 0; k < 16; k++)
      for (int i = 0; i < NC; i++) step(1'b1, 1'b0, 1'b1, 1500, i, "R8");
    idle(1'b1, 2);
    chk(cal_done === 1'b1, "R4 done kept", int'(cal_done), 1);
    readback("R4 table unchanged");
  endtask

  task automatic t_restart;
    step(1'b1, 1'b1, 1'b0, 0, 0, "R5");
    for (int i = 0; i < 3000; i++) step(1'b1, 1'b0, 1'b1, 900, i % NC, "R8");
    chk(cal_done === 1'b0, "R5 done low during partial", int'(cal_done), 0);
    calibrate(5, 60, 300);
    readback("R5 restart table");
  endtask

  initial begin
    ex_v[0] = 1'b0; ex_v[1] = 1'b0;
    ex_s[0] = '0;   ex_s[1] = '0;
    ex_r[0] = "";   ex_r[1] = "";
    for (int c = 0; c < NC; c++) begin
      exp_tab[c] = 0;
      edge_cell[c] = 1'b0;
    end
    t_reset();
    t_no_start();
    calibrate(0, 0, 10);
    readback("R2 table");
    t_run_rotated();
    t_saturate();
    t_ignore_after_done();
    t_restart();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        errors++;
        checks++;
        $display("FAIL watchdog R1 actual=%0d expected=%0d", cycles, 190000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

endmodule